// File: doc/BRIEF.md
# E1 Signalling Multiframe Aligner

This block finds and follows the 16-frame channel-associated-signalling multiframe of an E1 receive stream. The stream is already aligned to basic frames. Each basic frame has 32 timeslots of 8 bits. The block watches only the timeslot 16 byte. While searching, it locks to the first frame whose timeslot 16 upper nibble is 0000. From then on it counts frames. It checks the nibble again in every frame it predicts to be frame 0. It drops alignment once two predicted frame-0 nibbles in a row are wrong.

The host can force a fresh search with a control bit. The search starts only when that bit falls, and only if the bit was high across at least one frame strobe. On the transmit side, the block produces the remote multiframe alarm bit (the Y bit). In automatic mode the Y bit follows the sync flag. In manual mode it comes from a host bit. The block writes the Y bit into the outgoing timeslot 16 byte of transmit frame 0.

Top module: `cas_mf_align`

## Requirements
- R1: After a synchronous active-high `rst`, `mf_unsync` is 1, `mf_frame` is 0 and, in automatic mode, `tx_y` is 1.
- R2: While searching, only the byte with `rx_en`=1 and `rx_ts`=16 is examined. Bytes in other timeslots, even all-zero bytes, do not cause a lock. A timeslot 16 byte whose bits [7:4] are not 0000 also does not cause a lock.
- R3: While searching, the first timeslot 16 byte with bits [7:4]=0000 gives a lock. From the next cycle `mf_unsync` is 0 and `mf_frame` is 0.
- R4: While aligned, each `rx_fp` strobe advances `mf_frame` by one, and 15 wraps to 0. While searching, `mf_frame` reads 0.
- R5: While aligned, one errored frame-0 nibble followed by a correct one keeps alignment and clears the error count. The pattern bad, good, bad therefore keeps alignment.
- R6: While aligned, a second consecutive errored frame-0 nibble clears alignment in the cycle after its timeslot 16 byte (`mf_unsync`=1, `mf_frame`=0). The block then searches again.
- R7: A new search (`mf_unsync`=1 in the next cycle) starts on the 1-to-0 transition of `host_reframe`, but only if an `rx_fp` strobe arrived while the bit was 1. A high pulse that spans no frame strobe is ignored. While the bit stays high, alignment is unaffected.
- R8: With `host_y_manual`=0, `tx_y` equals `mf_unsync`.
- R9: With `host_y_manual`=1, `tx_y` equals `host_y_value`, whatever the sync state.
- R10: When `tx_mf_start`=1, `tx_sig_out` is `tx_sig_in` with index [2] (bit 6 counting 1..8 from the MSB) replaced by `tx_y`. When `tx_mf_start`=0, `tx_sig_out` equals `tx_sig_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fp | input | 1 | Receive basic-frame strobe, one cycle per frame |
| rx_en | input | 1 | Receive byte valid |
| rx_ts | input | 5 | Timeslot index of `rx_byte` |
| rx_byte | input | 8 | Receive timeslot byte |
| host_reframe | input | 1 | Search restart request, acts on its falling edge |
| host_y_manual | input | 1 | 1 selects the host value for the Y bit |
| host_y_value | input | 1 | Host Y bit value |
| tx_sig_in | input | 8 | Outgoing timeslot 16 byte before Y insertion |
| tx_mf_start | input | 1 | Marks `tx_sig_in` as frame 0 of the transmit multiframe |
| mf_unsync | output | 1 | 0 when aligned, 1 when not aligned |
| mf_frame | output | 4 | Frame number within the multiframe |
| tx_y | output | 1 | Remote multiframe alarm bit |
| tx_sig_out | output | 8 | Outgoing timeslot 16 byte after Y insertion |

## Verification
The hardest situation to reach is the error counter reset. The difference between one errored multiframe followed by a good one and two errored multiframes in a row shows up only after many frames, and only at the predicted frame-0 position. The bench keeps its own frame position model and builds whole 32-timeslot frames. It places a chosen nibble at each predicted frame 0, so bad-good-bad and bad-bad sequences land exactly there. The reframe rule is reached in the same way. The host bit is pulsed high once between frame strobes and once held across a full frame, and the sync flag is checked in the cycle after each fall.

// File: rtl/cas_mf_align.sv
module cas_mf_align #(
  parameter int FRAMES    = 16,
  parameter int TSLOTS    = 32,
  parameter int SIG_TS    = 16,
  parameter int ERR_LIMIT = 2,
  localparam int FW = $clog2(FRAMES),
  localparam int TW = $clog2(TSLOTS),
  localparam int EW = $clog2(ERR_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_fp,
  input  logic          rx_en,
  input  logic [TW-1:0] rx_ts,
  input  logic [7:0]    rx_byte,
  input  logic          host_reframe,
  input  logic          host_y_manual,
  input  logic          host_y_value,
  input  logic [7:0]    tx_sig_in,
  input  logic          tx_mf_start,
  output logic          mf_unsync,
  output logic [FW-1:0] mf_frame,
  output logic          tx_y,
  output logic [7:0]    tx_sig_out
);

  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);
  localparam logic [EW-1:0] LAST_ERR   = EW'(ERR_LIMIT - 1);

  logic          rf_q, rf_armed, fire;
  logic          sig_hit, mfas_ok, at_f0;
  logic [FW-1:0] fcnt;
  logic [EW-1:0] errs;

  assign sig_hit = rx_en && (rx_ts == TW'(SIG_TS));
  assign mfas_ok = (rx_byte[7:4] == 4'b0000);
  assign at_f0   = (fcnt == '0);
  assign fire    = rf_q && !host_reframe && rf_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_q     <= 1'b0;
      rf_armed <= 1'b0;
    end else begin
      rf_q <= host_reframe;
      if (!host_reframe)
        rf_armed <= 1'b0;
      else if (rx_fp)
        rf_armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || fire) begin
      mf_unsync <= 1'b1;
      fcnt      <= '0;
      errs      <= '0;
    end else if (mf_unsync) begin
      if (sig_hit && mfas_ok) begin
        mf_unsync <= 1'b0;
        fcnt      <= '0;
        errs      <= '0;
      end
    end else begin
      if (rx_fp)
        fcnt <= (fcnt == LAST_FRAME) ? '0 : fcnt + 1'b1;
      if (sig_hit && at_f0) begin
        if (mfas_ok)
          errs <= '0;
        else if (errs == LAST_ERR) begin
          mf_unsync <= 1'b1;
          fcnt      <= '0;
          errs      <= '0;
        end else
          errs <= errs + 1'b1;
      end
    end
  end

  assign mf_frame   = fcnt;
  assign tx_y       = host_y_manual ? host_y_value : mf_unsync;
  assign tx_sig_out = tx_mf_start ? {tx_sig_in[7:3], tx_y, tx_sig_in[1:0]} : tx_sig_in;

  // R3
  acquire_chk: assert property (@(posedge clk) disable iff (rst)
    (mf_unsync && !fire && sig_hit && mfas_ok) |=> (!mf_unsync && mf_frame == '0));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!mf_unsync && !fire && rx_fp && !(sig_hit && at_f0 && !mfas_ok))
      |=> (mf_frame == $past(mf_frame) + 1'b1));

  // R5
  single_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!mf_unsync && !fire && sig_hit && at_f0 && !mfas_ok && errs != LAST_ERR) |=> !mf_unsync);

  // R6
  loss_chk: assert property (@(posedge clk) disable iff (rst)
    (!mf_unsync && !fire && sig_hit && at_f0 && !mfas_ok && errs == LAST_ERR)
      |=> (mf_unsync && mf_frame == '0));

  // R7
  reframe_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> mf_unsync);

  // R7
  no_early_chk: assert property (@(posedge clk) disable iff (rst)
    (!mf_unsync && host_reframe && !(sig_hit && at_f0 && !mfas_ok)) |=> !mf_unsync);

endmodule

// File: tb/test_cas_mf_align.sv
module test_cas_mf_align;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_fp = 1'b0, rx_en = 1'b0;
  logic [4:0] rx_ts = '0;
  logic [7:0] rx_byte = '0;
  logic       host_reframe = 1'b0, host_y_manual = 1'b0, host_y_value = 1'b0;
  logic [7:0] tx_sig_in = '0;
  logic       tx_mf_start = 1'b0;
  logic       mf_unsync, tx_y;
  logic [3:0] mf_frame;
  logic [7:0] tx_sig_out;

  int total = 0, bad = 0, pos = 0;
  bit finished = 0;

  localparam logic [7:0] GOOD = 8'h0B, FILL = 8'h5B, ERRB = 8'h70;

  cas_mf_align i_cas_mf_align (
    .clk(clk), .rst(rst), .rx_fp(rx_fp), .rx_en(rx_en), .rx_ts(rx_ts),
    .rx_byte(rx_byte), .host_reframe(host_reframe), .host_y_manual(host_y_manual),
    .host_y_value(host_y_value), .tx_sig_in(tx_sig_in), .tx_mf_start(tx_mf_start),
    .mf_unsync(mf_unsync), .mf_frame(mf_frame), .tx_y(tx_y), .tx_sig_out(tx_sig_out));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_frame(input logic [7:0] ts16);
    for (int t = 0; t < 32; t++) begin
      @(negedge clk);
      rx_fp   = (t == 0);
      rx_en   = 1'b1;
      rx_ts   = 5'(t);
      rx_byte = (t == 16) ? ts16 : 8'h00;
    end
    @(negedge clk);
    rx_fp = 1'b0;
    rx_en = 1'b0;
  endtask

  // send one aligned frame; byte at frame 0 chosen by caller
  task automatic aligned_frame(input logic [7:0] f0byte, input string req);
    drive_frame(pos == 0 ? f0byte : FILL);
    chk(req, {31'd0, mf_unsync}, 32'd0);
    chk(req, {28'd0, mf_frame}, 32'(pos));
    pos = (pos + 1) % 16;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 unsync", {31'd0, mf_unsync}, 32'd1);
    chk("R1 frame", {28'd0, mf_frame}, 32'd0);
    chk("R1 y", {31'd0, tx_y}, 32'd1);
  endtask

  task automatic t_search_ignore;
    drive_frame(FILL);
    chk("R2 other nibble", {31'd0, mf_unsync}, 32'd1);
    drive_frame(8'h80);
    chk("R2 nibble 1000", {31'd0, mf_unsync}, 32'd1);
    chk("R4 frame in search", {28'd0, mf_frame}, 32'd0);
  endtask

  task automatic t_acquire;
    drive_frame(GOOD);
    chk("R3 locked", {31'd0, mf_unsync}, 32'd0);
    chk("R3 frame0", {28'd0, mf_frame}, 32'd0);
    pos = 1;
    for (int i = 0; i < 17; i++) aligned_frame(GOOD, "R4 count");
  endtask

  task automatic t_y_auto;
    #1;
    chk("R8 y aligned", {31'd0, tx_y}, 32'd0);
    tx_sig_in = 8'hFF; tx_mf_start = 1'b1; #1;
    chk("R10 insert 0", {24'd0, tx_sig_out}, 32'hFB);
    tx_mf_start = 1'b0; #1;
    chk("R10 pass", {24'd0, tx_sig_out}, 32'hFF);
  endtask

  task automatic t_errors;
    while (pos != 0) aligned_frame(GOOD, "R5 run");
    aligned_frame(ERRB, "R5 first bad");
    while (pos != 0) aligned_frame(GOOD, "R5 run");
    aligned_frame(GOOD, "R5 good");
    while (pos != 0) aligned_frame(GOOD, "R5 run");
    aligned_frame(ERRB, "R5 bad again");
    while (pos != 0) aligned_frame(GOOD, "R5 run");
    drive_frame(ERRB);
    chk("R6 lost", {31'd0, mf_unsync}, 32'd1);
    chk("R6 frame", {28'd0, mf_frame}, 32'd0);
    #1;
    chk("R8 y lost", {31'd0, tx_y}, 32'd1);
    tx_sig_in = 8'h00; tx_mf_start = 1'b1; #1;
    chk("R10 insert 1", {24'd0, tx_sig_out}, 32'h04);
    tx_mf_start = 1'b0;
    drive_frame(FILL);
    chk("R6 search", {31'd0, mf_unsync}, 32'd1);
    drive_frame(GOOD);
    chk("R6 relock", {31'd0, mf_unsync}, 32'd0);
    pos = 1;
  endtask

  task automatic t_reframe;
    aligned_frame(GOOD, "R7 pre");
    host_reframe = 1'b1;
    repeat (3) @(negedge clk);
    host_reframe = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 short pulse", {31'd0, mf_unsync}, 32'd0);
    host_reframe = 1'b1;
    aligned_frame(GOOD, "R7 held");
    host_reframe = 1'b0;
    @(negedge clk);
    chk("R7 fall", {31'd0, mf_unsync}, 32'd1);
    chk("R7 frame", {28'd0, mf_frame}, 32'd0);
    drive_frame(FILL);
    drive_frame(GOOD);
    chk("R7 new lock", {31'd0, mf_unsync}, 32'd0);
    pos = 1;
    aligned_frame(GOOD, "R7 new count");
  endtask

  task automatic t_y_manual;
    host_y_manual = 1'b1; host_y_value = 1'b1; #1;
    chk("R9 manual1", {31'd0, tx_y}, 32'd1);
    host_y_value = 1'b0; #1;
    chk("R9 manual0", {31'd0, tx_y}, 32'd0);
    tx_sig_in = 8'hFF; tx_mf_start = 1'b1; #1;
    chk("R10 manual insert", {24'd0, tx_sig_out}, 32'hFB);
    host_reframe = 1'b1;
    drive_frame(FILL);
    host_reframe = 1'b0;
    @(negedge clk);
    host_y_value = 1'b0; #1;
    chk("R9 manual unsync", {31'd0, tx_y}, 32'd0);
    host_y_manual = 1'b0; tx_mf_start = 1'b0; #1;
    chk("R8 back auto", {31'd0, tx_y}, 32'd1);
  endtask

  initial begin
    t_reset;
    t_search_ignore;
    t_acquire;
    t_y_auto;
    t_errors;
    t_reframe;
    t_y_manual;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule